// File: doc/BRIEF.md
# Weekly Alarm and Seconds Interrupt

This block watches the minute, hour and weekday that a separate time-counting core presents, and compares them with a programmed alarm time. The alarm minute and hour are BCD values. The day is chosen through a seven-bit mask, one bit per weekday. The mask lets one alarm repeat on any set of days in the week. The alarm resolves only to the minute. It fires when the counter enters the programmed minute, which is second 00.

A second interrupt source pulses once for every seconds increment of the counter core. Software can use this pulse to count down to an exact second after the alarm has brought it near. Each source has its own enable bit in a control register, and both outputs are level interrupts. A small write/read port holds the alarm minute, the alarm hour, the weekday mask and the control register.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset every register reads 0, and `alarm_irq` and `sec_irq` are both low.
- R2: The register map uses `reg_addr` 0 for control, 1 for alarm minute (8-bit BCD), 2 for alarm hour (8-bit BCD) and 3 for the weekday mask (bits 6..0, where bit n selects weekday n). In the control register, bit 4 enables the alarm and bit 3 enables the seconds interrupt. Bits that are not implemented read back as 0.
- R3: With the alarm enabled, `alarm_irq` goes high on the first clock edge after `cur_min` and `cur_hour` become equal to the alarm minute and hour while the mask bit for `cur_wday` is set.
- R4: If the mask bit for the current weekday is clear, a matching minute and hour never raise `alarm_irq`.
- R5: Once raised, `alarm_irq` stays high after the time has moved past the alarm minute. It falls on the clock edge after the alarm-enable bit is cleared.
- R6: The alarm fires only when the match condition begins. Enabling the alarm while the time already matches does not raise `alarm_irq`.
- R7: When several mask bits are set, the alarm fires on each selected weekday and on no other day.
- R8: With the seconds enable set, `sec_irq` is high for exactly the one clock cycle after each cycle in which `sec_tick` is high.
- R9: With the seconds enable clear, `sec_tick` has no effect on `sec_irq`.
- R10: Writing 0 to the control register drops both interrupt outputs and keeps them low.
- R11: After the alarm is cleared and enabled again, the next start of a match raises `alarm_irq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cur_min | input | 8 | Current minute from the counter core, BCD |
| cur_hour | input | 8 | Current hour from the counter core, BCD |
| cur_wday | input | 3 | Current weekday, binary 0..6 |
| sec_tick | input | 1 | One-cycle pulse on each seconds increment |
| alarm_irq | output | 1 | Alarm interrupt, level |
| sec_irq | output | 1 | Seconds interrupt, one-cycle pulse |

## Verification
The assertions assume that `cur_wday` stays within 0..6 and that two `sec_tick` pulses are always separated by at least one low cycle. The one-cycle width of `sec_irq` and the weekday selection both rely on these assumptions. The bench drives only legal weekday values. Its ticks are single-cycle pulses separated by idle cycles. It changes the time inputs only on falling clock edges, so each match begins at a known rising edge.

// File: rtl/rtc_alarm_pkg.sv
// Package: register addresses and control bit positions shared by the
// alarm block. Assumes an address space of four registers.
package rtc_alarm_pkg;
    localparam int ADDR_W         = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_AMIN = 2'd1;
    localparam logic [ADDR_W-1:0] A_AHR  = 2'd2;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd3;
    localparam int CTRL_ALM_BIT   = 4;
    localparam int CTRL_SEC_BIT   = 3;
endpackage

// File: rtl/rtc_alarm_regs.sv
// Register file for the alarm settings and the two enable bits.
// Assumes DW > CTRL_ALM_BIT and DW >= DAYS. Reads are combinational.
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DAYS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     alm_min,
    output logic [DW-1:0]     alm_hour,
    output logic [DAYS-1:0]   alm_mask,
    output logic              alm_en,
    output logic              sec_en
);
    localparam int PAD = DW - DAYS;

    // Update the addressed register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_min  <= '0;
            alm_hour <= '0;
            alm_mask <= '0;
            alm_en   <= 1'b0;
            sec_en   <= 1'b0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    alm_en <= wdata[CTRL_ALM_BIT];
                    sec_en <= wdata[CTRL_SEC_BIT];
                end
                A_AMIN: alm_min  <= wdata;
                A_AHR:  alm_hour <= wdata;
                default: alm_mask <= wdata[DAYS-1:0];
            endcase
        end
    end

    // Select read data; unimplemented bits return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTRL_ALM_BIT] = alm_en;
                rdata[CTRL_SEC_BIT] = sec_en;
            end
            A_AMIN: rdata = alm_min;
            A_AHR:  rdata = alm_hour;
            default: begin
                if (PAD > 0) rdata = {{PAD{1'b0}}, alm_mask};
                else         rdata[DAYS-1:0] = alm_mask;
            end
        endcase
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Compares current time against the alarm and raises a sticky interrupt
// when the match starts. Assumes time inputs change synchronously to clk.
// The interrupt is held until the enable bit is cleared.
module rtc_alarm_match #(
    parameter int DW   = 8,
    parameter int DAYS = 7,
    parameter int WDW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   cur_min,
    input  logic [DW-1:0]   cur_hour,
    input  logic [WDW-1:0]  cur_wday,
    input  logic [DW-1:0]   alm_min,
    input  logic [DW-1:0]   alm_hour,
    input  logic [DAYS-1:0] alm_mask,
    input  logic            alm_en,
    output logic            irq
);
    localparam logic [WDW:0] DAYS_V = DAYS[WDW:0];

    logic day_ok;
    logic hit;
    logic hit_q;

    // Weekday selection through the mask; out-of-range days never select.
    always_comb begin
        day_ok = 1'b0;
        if ({1'b0, cur_wday} < DAYS_V) day_ok = alm_mask[cur_wday];
    end

    // Full match of minute, hour and day.
    always_comb hit = day_ok && (cur_min == alm_min) && (cur_hour == alm_hour);

    // Remember the previous match state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    // Set on a new match while enabled; clear when the enable drops.
    always_ff @(posedge clk) begin
        if (!rst_n)               irq <= 1'b0;
        else if (!alm_en)         irq <= 1'b0;
        else if (hit && !hit_q)   irq <= 1'b1;
    end
endmodule

// File: rtl/rtc_sec_irq.sv
// Turns each seconds tick into a one-cycle interrupt pulse when enabled.
// Assumes sec_tick is a single-cycle pulse.
module rtc_sec_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic sec_en,
    output logic irq
);
    // Register the gated tick.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= sec_tick & sec_en;
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
// Top: weekly minute-resolution alarm plus per-second interrupt.
// Assumes the time inputs come from a counter core in the clk domain,
// with cur_wday in 0..DAYS-1.
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DAYS = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DW-1:0]            reg_wdata,
    output logic [DW-1:0]            reg_rdata,
    input  logic [DW-1:0]            cur_min,
    input  logic [DW-1:0]            cur_hour,
    input  logic [$clog2(DAYS)-1:0]  cur_wday,
    input  logic                     sec_tick,
    output logic                     alarm_irq,
    output logic                     sec_irq
);
    localparam int WDW = $clog2(DAYS);

    logic [DW-1:0]   alm_min;
    logic [DW-1:0]   alm_hour;
    logic [DAYS-1:0] alm_mask;
    logic            alm_en;
    logic            sec_en;

    rtc_alarm_regs #(.DW(DW), .DAYS(DAYS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .alm_min(alm_min),
        .alm_hour(alm_hour), .alm_mask(alm_mask), .alm_en(alm_en),
        .sec_en(sec_en)
    );

    rtc_alarm_match #(.DW(DW), .DAYS(DAYS), .WDW(WDW)) u_match (
        .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .alm_min(alm_min), .alm_hour(alm_hour),
        .alm_mask(alm_mask), .alm_en(alm_en), .irq(alarm_irq)
    );

    rtc_sec_irq u_sec (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .sec_en(sec_en),
        .irq(sec_irq)
    );
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
// Checker for rtc_alarm_irq. Assumes cur_wday < DAYS and sec_tick pulses
// are separated by at least one low cycle.
module rtc_alarm_irq_chk #(
    parameter int DW   = 8,
    parameter int DAYS = 7,
    parameter int WDW  = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DW-1:0]   cur_min,
    input logic [DW-1:0]   cur_hour,
    input logic [WDW-1:0]  cur_wday,
    input logic            sec_tick,
    input logic [DW-1:0]   alm_min,
    input logic [DW-1:0]   alm_hour,
    input logic [DAYS-1:0] alm_mask,
    input logic            alm_en,
    input logic            sec_en,
    input logic            alarm_irq,
    input logic            sec_irq
);
    logic [DAYS-1:0] shifted;
    logic            hit_c;
    logic            hit_d;

    // Independent form of the match: shift the mask down to the day.
    always_comb begin
        shifted = alm_mask >> cur_wday;
        hit_c   = shifted[0] && (cur_min == alm_min) && (cur_hour == alm_hour);
    end

    // Delayed match seen by the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_d <= 1'b0;
        else        hit_d <= hit_c;
    end

    // R3: a new alarm needs a match that has just begun, with enable set.
    a_r3_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> ($past(hit_c) && $past(alm_en)));
    // R6: no rise while the match was already present a cycle earlier.
    a_r6_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> !$past(hit_d));
    // R5: a raised alarm holds while its enable stays set.
    a_r5_alarm_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && alm_en) |=> alarm_irq);
    // R10: an alarm level never survives a cleared enable.
    a_r10_alarm_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> $past(alm_en));
    // R8: an enabled tick produces the seconds interrupt.
    a_r8_sec_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && sec_en) |=> sec_irq);
    // R8: the seconds interrupt is a single-cycle pulse.
    a_r8_sec_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        sec_irq |=> !sec_irq);
    // R9: no seconds interrupt without an enabled tick.
    a_r9_sec_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sec_irq |-> ($past(sec_tick) && $past(sec_en)));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.DW(DW), .DAYS(DAYS), .WDW(WDW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .sec_tick(sec_tick), .alm_min(alm_min),
    .alm_hour(alm_hour), .alm_mask(alm_mask), .alm_en(alm_en),
    .sec_en(sec_en), .alarm_irq(alarm_irq), .sec_irq(sec_irq)
);

// File: tb/rtc_alarm_irq_tb.sv
// Directed bench for rtc_alarm_irq: one task per scenario.
module rtc_alarm_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] cur_min = 8'h00;
    logic [7:0] cur_hour = 8'h00;
    logic [2:0] cur_wday = 3'd0;
    logic       sec_tick = 1'b0;
    logic       alarm_irq;
    logic       sec_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_alarm_irq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_wday(cur_wday), .sec_tick(sec_tick),
        .alarm_irq(alarm_irq), .sec_irq(sec_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rdata, exp);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [2:0] d);
        @(negedge clk);
        cur_hour = h; cur_min = m; cur_wday = d;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 2'd0, 8'h00);
        rd_chk("R1 min", 2'd1, 8'h00);
        rd_chk("R1 hour", 2'd2, 8'h00);
        rd_chk("R1 mask", 2'd3, 8'h00);
        chk("R1 alarm_irq", {7'd0, alarm_irq}, 8'h00);
        chk("R1 sec_irq", {7'd0, sec_irq}, 8'h00);
    endtask

    task automatic t_regs();
        wr(2'd1, 8'h59); rd_chk("R2 min", 2'd1, 8'h59);
        wr(2'd2, 8'h23); rd_chk("R2 hour", 2'd2, 8'h23);
        wr(2'd3, 8'hFF); rd_chk("R2 mask bit7 zero", 2'd3, 8'h7F);
        wr(2'd0, 8'hFF); rd_chk("R2 ctrl bits 4,3", 2'd0, 8'h18);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_alarm_basic();
        wr(2'd1, 8'h30); wr(2'd2, 8'h07); wr(2'd3, 8'h04);
        set_time(8'h07, 8'h29, 3'd2);
        wr(2'd0, 8'h10);
        idle(2);
        #1 chk("R3 no alarm before match", {7'd0, alarm_irq}, 8'h00);
        set_time(8'h07, 8'h30, 3'd2);
        #1 chk("R3 not before edge", {7'd0, alarm_irq}, 8'h00);
        after_edge();
        chk("R3 alarm on match", {7'd0, alarm_irq}, 8'h01);
        set_time(8'h07, 8'h31, 3'd2);
        idle(3);
        #1 chk("R5 alarm held", {7'd0, alarm_irq}, 8'h01);
        wr(2'd0, 8'h00);
        after_edge();
        chk("R5 alarm cleared by enable", {7'd0, alarm_irq}, 8'h00);
        // R11: re-arm and hit the same minute again.
        wr(2'd0, 8'h10);
        set_time(8'h07, 8'h30, 3'd2);
        after_edge();
        chk("R11 alarm re-fires", {7'd0, alarm_irq}, 8'h01);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_mask_block();
        set_time(8'h07, 8'h29, 3'd3);
        wr(2'd0, 8'h10);
        set_time(8'h07, 8'h30, 3'd3);
        idle(3);
        #1 chk("R4 masked day no alarm", {7'd0, alarm_irq}, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_enable_inside();
        set_time(8'h07, 8'h30, 3'd2);
        idle(2);
        wr(2'd0, 8'h10);
        idle(3);
        #1 chk("R6 enable during match", {7'd0, alarm_irq}, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_multi_day();
        wr(2'd3, 8'h22);
        for (int d = 0; d < 7; d++) begin
            set_time(8'h07, 8'h29, 3'(d));
            wr(2'd0, 8'h10);
            set_time(8'h07, 8'h30, 3'(d));
            after_edge();
            chk($sformatf("R7 day %0d", d), {7'd0, alarm_irq},
                (d == 1 || d == 5) ? 8'h01 : 8'h00);
            wr(2'd0, 8'h00);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic t_sec();
        wr(2'd0, 8'h08);
        for (int k = 0; k < 3; k++) begin
            pulse_tick();
            chk("R8 sec pulse high", {7'd0, sec_irq}, 8'h01);
            @(negedge clk); sec_tick = 1'b0;
            after_edge();
            chk("R8 sec pulse one cycle", {7'd0, sec_irq}, 8'h00);
        end
        wr(2'd0, 8'h00);
        pulse_tick();
        chk("R9 disabled tick ignored", {7'd0, sec_irq}, 8'h00);
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic t_ctrl_zero();
        set_time(8'h07, 8'h29, 3'd1);
        wr(2'd0, 8'h18);
        set_time(8'h07, 8'h30, 3'd1);
        after_edge();
        chk("R10 alarm set first", {7'd0, alarm_irq}, 8'h01);
        wr(2'd0, 8'h00);
        after_edge();
        chk("R10 alarm off", {7'd0, alarm_irq}, 8'h00);
        pulse_tick();
        chk("R10 sec off", {7'd0, sec_irq}, 8'h00);
        @(negedge clk); sec_tick = 1'b0;
        rd_chk("R10 ctrl reads zero", 2'd0, 8'h00);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_regs();
        t_alarm_basic();
        t_mask_block();
        t_enable_inside();
        t_multi_day();
        t_sec();
        t_ctrl_zero();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule